// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that runs entirely on its own slow clock. A free-running up counter measures a programmable interval. When the interval runs out, the block first raises a sticky interrupt flag, and optionally a wake-up request. It then opens a grace window of selectable length. If software restarts the count before the window closes, nothing further happens. If it does not, the block drives a system reset pulse of fixed length.

Software sees a register-style set of controls:
- an enable;
- a 4-bit interval code and a 2-bit grace code;
- individual enables for interrupt, reset and wake-up;
- write-1-to-clear strobes for the three sticky flags;
- a restart strobe.

A configuration input, sampled once after power-on reset, can force the watchdog to run even when the software enable is clear. A second input tells the block whether its clock comes from a low-speed source, which is the only case in which wake-up is permitted.

Top module: `wdog_two_stage`

## Requirements
- R1: The interval select code n picks a time-out period of 2^min(4+2n, CNT_W) cycles for n from 0 to 8, and 2^CNT_W cycles for codes 9 to 15. The interrupt flag rises exactly one period after the clock edge that samples a restart.
- R2: A time-out sets the sticky interrupt flag. The `irq` output is high only while both the flag and `ctl_irq_en` are high.
- R3: The grace code selects the delay: 00 gives 1026 cycles, 01 gives 130, 10 gives 18 and 11 gives 3. The code is taken at the time-out. `sys_rst` rises exactly that many cycles after the interrupt flag rises, provided `ctl_rst_en` was high at the time-out.
- R4: `sys_rst` stays high for exactly PULSE_LEN cycles (63 by default). The reset flag is set in the same cycle that `sys_rst` rises.
- R5: A time-out with `ctl_rst_en` low starts no grace window. It produces no reset pulse and does not set the reset flag.
- R6: A time-out sets the wake-up flag, and drives `wake_req` high, only when `ctl_wake_en` and `src_is_slow` are both high at that time-out.
- R7: A restart clears the counter and cancels a pending grace window, so no reset pulse follows.
- R8: While the block is neither enabled nor forced, the counter is held at zero, any grace window is dropped, and no flag is set.
- R9: `cfg_force_en` is sampled on the first clock after reset is released. If it was high, the watchdog runs with `ctl_en` low. Later changes of `cfg_force_en` have no effect.
- R10: A 1 on a flag's clear strobe clears that flag. If the flag is set and cleared in the same cycle, the set wins.
- R11: Further time-outs during a grace window or a reset pulse neither restart the window nor lengthen the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_force_en | input | 1 | Forced-enable configuration, sampled once after reset |
| src_is_slow | input | 1 | High when the watchdog clock comes from a low-speed source |
| ctl_en | input | 1 | Software enable |
| ctl_tsel | input | 4 | Interval select code |
| ctl_dsel | input | 2 | Grace delay select code |
| ctl_irq_en | input | 1 | Interrupt output enable |
| ctl_rst_en | input | 1 | Reset issue enable |
| ctl_wake_en | input | 1 | Wake-up enable |
| restart | input | 1 | Counter restart strobe |
| clr_irq | input | 1 | Write-1 clear of the interrupt flag |
| clr_rst | input | 1 | Write-1 clear of the reset flag |
| clr_wake | input | 1 | Write-1 clear of the wake-up flag |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake-up request |
| sys_rst | output | 1 | System reset pulse, active high |
| irq_flag | output | 1 | Sticky interrupt flag |
| rst_flag | output | 1 | Sticky reset flag |
| wake_flag | output | 1 | Sticky wake-up flag |

## Verification
A counter that advances or wraps at the wrong point moves the rise of the interrupt flag away from the exact period count. That error shows within a single interval after a restart. A grace or pulse counter with a bad terminal value, or a sequencer state that fails to leave its delay state on restart, shows on `sys_rst`. Either the rise lands at the wrong distance from the flag, the pulse has the wrong width, or a pulse appears where a restart should have cancelled it. That is visible within one grace window plus 63 cycles. A forced-enable latch that keeps following its input shows as counting, or silence, within one interval after the input changes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned TSEL_W = 4;
  localparam int unsigned DSEL_W = 2;
  localparam int unsigned DLY_W  = 11;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_GRACE = 2'd1,
    SEQ_PULSE = 2'd2
  } seq_state_t;

  // Exponent of the time-out period for a select code, capped at the counter width.
  function automatic int unsigned interval_exp(input logic [TSEL_W-1:0] code,
                                               input int unsigned cnt_w);
    int unsigned e;
    if (code > 4'd8) e = cnt_w;
    else             e = 32'd4 + 32'd2 * 32'(code);
    if (e > cnt_w)   e = cnt_w;
    return e;
  endfunction

  // Grace delay length for a select code.
  function automatic logic [DLY_W-1:0] grace_cycles(input logic [DSEL_W-1:0] code);
    logic [DLY_W-1:0] len;
    case (code)
      2'b00:   len = 11'd1026;
      2'b01:   len = 11'd130;
      2'b10:   len = 11'd18;
      default: len = 11'd3;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/wdog_interval_ctr.sv
module wdog_interval_ctr
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                restart,
  input  logic [TSEL_W-1:0]   tsel,
  output logic [CNT_W-1:0]    cnt,
  output logic                tout_evt
);

  logic [CNT_W-1:0] term;
  int unsigned      exp_w;

  always_comb begin
    exp_w = interval_exp(tsel, CNT_W);
    term  = '0;
    for (int i = 0; i < int'(CNT_W); i++) begin
      term[i] = (32'(i) < exp_w);
    end
  end

  assign tout_evt = run && !restart && (cnt == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || restart || tout_evt) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdog_reset_seq.sv
module wdog_reset_seq
  import wdog_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 63,
  localparam int unsigned PLS_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               cancel,
  input  logic [DSEL_W-1:0]  dsel,
  output logic               grace_busy,
  output logic               pulse_start,
  output logic               sys_rst
);

  seq_state_t       state;
  logic [DLY_W-1:0] dly_cnt;
  logic [DLY_W-1:0] dly_len;
  logic [PLS_W-1:0] pls_cnt;
  logic             pulse_last;

  assign grace_busy  = (state == SEQ_GRACE);
  assign pulse_start = grace_busy && !cancel && (dly_cnt == dly_len - 1'b1);
  assign pulse_last  = (state == SEQ_PULSE) && (pls_cnt == PLS_W'(PULSE_LEN - 1));
  assign sys_rst     = (state == SEQ_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      dly_cnt <= '0;
      dly_len <= '0;
      pls_cnt <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (arm) begin
            state   <= SEQ_GRACE;
            dly_cnt <= '0;
            dly_len <= grace_cycles(dsel);
          end
        end
        SEQ_GRACE: begin
          if (cancel) begin
            state <= SEQ_IDLE;
          end else if (pulse_start) begin
            state   <= SEQ_PULSE;
            pls_cnt <= '0;
          end else begin
            dly_cnt <= dly_cnt + 1'b1;
          end
        end
        SEQ_PULSE: begin
          if (pulse_last) state <= SEQ_IDLE;
          else            pls_cnt <= pls_cnt + 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wdog_flag_bank.sv
module wdog_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);

  for (genvar gi = 0; gi < N; gi++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[gi] <= 1'b0;
      else        flags[gi] <= set[gi] | (flags[gi] & ~clr[gi]);
    end
  end

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned PULSE_LEN = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_force_en,
  input  logic              src_is_slow,
  input  logic              ctl_en,
  input  logic [3:0]        ctl_tsel,
  input  logic [1:0]        ctl_dsel,
  input  logic              ctl_irq_en,
  input  logic              ctl_rst_en,
  input  logic              ctl_wake_en,
  input  logic              restart,
  input  logic              clr_irq,
  input  logic              clr_rst,
  input  logic              clr_wake,
  output logic              irq,
  output logic              wake_req,
  output logic              sys_rst,
  output logic              irq_flag,
  output logic              rst_flag,
  output logic              wake_flag
);

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned F_IRQ  = 0;
  localparam int unsigned F_RST  = 1;
  localparam int unsigned F_WAKE = 2;

  logic             cap_done;
  logic             force_q;
  logic             run;
  logic [CNT_W-1:0] cnt_q;
  logic             tout_evt;
  logic             grace_busy;
  logic             pulse_start;
  logic [FLAG_N-1:0] flag_set;
  logic [FLAG_N-1:0] flag_clr;
  logic [FLAG_N-1:0] flag_q;

  // One-time capture of the forced-enable configuration after reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_done <= 1'b0;
      force_q  <= 1'b0;
    end else if (!cap_done) begin
      cap_done <= 1'b1;
      force_q  <= cfg_force_en;
    end
  end

  assign run = cap_done && (ctl_en || force_q);

  wdog_interval_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .restart  (restart),
    .tsel     (ctl_tsel),
    .cnt      (cnt_q),
    .tout_evt (tout_evt)
  );

  wdog_reset_seq #(.PULSE_LEN(PULSE_LEN)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (tout_evt && ctl_rst_en),
    .cancel      (restart || !run),
    .dsel        (ctl_dsel),
    .grace_busy  (grace_busy),
    .pulse_start (pulse_start),
    .sys_rst     (sys_rst)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[F_IRQ]  = tout_evt;
    flag_set[F_RST]  = pulse_start;
    flag_set[F_WAKE] = tout_evt && ctl_wake_en && src_is_slow;
    flag_clr         = '0;
    flag_clr[F_IRQ]  = clr_irq;
    flag_clr[F_RST]  = clr_rst;
    flag_clr[F_WAKE] = clr_wake;
  end

  wdog_flag_bank #(.N(FLAG_N)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .flags (flag_q)
  );

  assign irq_flag  = flag_q[F_IRQ];
  assign rst_flag  = flag_q[F_RST];
  assign wake_flag = flag_q[F_WAKE];
  assign irq       = irq_flag && ctl_irq_en;
  assign wake_req  = wake_flag;

endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned PULSE_LEN = 63
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             restart,
  input logic             tout_evt,
  input logic [CNT_W-1:0] cnt_q,
  input logic             grace_busy,
  input logic             ctl_rst_en,
  input logic             ctl_wake_en,
  input logic             src_is_slow,
  input logic             sys_rst,
  input logic             irq_flag,
  input logic             rst_flag,
  input logic             wake_flag
);

  localparam int unsigned RUN_W = $clog2(PULSE_LEN + 2);

  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= '0;
    else if (sys_rst) run_len <= run_len + 1'b1;
    else              run_len <= '0;
  end

  assert_flag_follows_tout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tout_evt |=> irq_flag);

  assert_grace_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grace_busy) |-> $past(ctl_rst_en && tout_evt));

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (run_len == RUN_W'(PULSE_LEN)));

  assert_pulse_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> (run_len < RUN_W'(PULSE_LEN)));

  assert_rst_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> rst_flag);

  assert_wake_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(tout_evt && ctl_wake_en && src_is_slow));

  assert_restart_cancels_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && grace_busy) |=> !grace_busy);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((cnt_q == '0) && !grace_busy));

endmodule

bind wdog_two_stage wdog_two_stage_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .restart     (restart),
  .tout_evt    (tout_evt),
  .cnt_q       (cnt_q),
  .grace_busy  (grace_busy),
  .ctl_rst_en  (ctl_rst_en),
  .ctl_wake_en (ctl_wake_en),
  .src_is_slow (src_is_slow),
  .sys_rst     (sys_rst),
  .irq_flag    (irq_flag),
  .rst_flag    (rst_flag),
  .wake_flag   (wake_flag)
);

// File: tb/wdog_two_stage_test.sv
`timescale 1ns/1ps
module wdog_two_stage_test;

  localparam int unsigned CNT_W     = 10;
  localparam int unsigned PULSE_LEN = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_force_en = 1'b0, src_is_slow = 1'b0, ctl_en = 1'b0;
  logic [3:0] ctl_tsel = 4'd0;
  logic [1:0] ctl_dsel = 2'd0;
  logic ctl_irq_en = 1'b0, ctl_rst_en = 1'b0, ctl_wake_en = 1'b0;
  logic restart = 1'b0, clr_irq = 1'b0, clr_rst = 1'b0, clr_wake = 1'b0;
  logic irq, wake_req, sys_rst, irq_flag, rst_flag, wake_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  wdog_two_stage #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_force_en(cfg_force_en), .src_is_slow(src_is_slow),
    .ctl_en(ctl_en), .ctl_tsel(ctl_tsel), .ctl_dsel(ctl_dsel), .ctl_irq_en(ctl_irq_en),
    .ctl_rst_en(ctl_rst_en), .ctl_wake_en(ctl_wake_en), .restart(restart),
    .clr_irq(clr_irq), .clr_rst(clr_rst), .clr_wake(clr_wake), .irq(irq),
    .wake_req(wake_req), .sys_rst(sys_rst), .irq_flag(irq_flag), .rst_flag(rst_flag),
    .wake_flag(wake_flag)
  );

  function automatic int exp_period(input int code);
    int e;
    e = (code > 8) ? CNT_W : 4 + 2 * code;
    if (e > CNT_W) e = CNT_W;
    return 1 << e;
  endfunction

  function automatic int exp_grace(input int code);
    int t[4] = '{1026, 130, 18, 3};
    return t[code];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic apply_reset(input bit force_val);
    rst_n = 1'b0;
    cfg_force_en = force_val;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Restart plus clear of all flags; returns at the negedge right after the sampling edge.
  task automatic do_restart();
    restart = 1'b1; clr_irq = 1'b1; clr_rst = 1'b1; clr_wake = 1'b1;
    @(negedge clk);
    restart = 1'b0; clr_irq = 1'b0; clr_rst = 1'b0; clr_wake = 1'b0;
  endtask

  task automatic wait_flag(output int n, input int maxc);
    n = 0;
    while (!irq_flag && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!irq && !wake_req && !sys_rst && !irq_flag && !rst_flag && !wake_flag,
          "reset state", {irq, wake_req, sys_rst, irq_flag, rst_flag, wake_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_disabled_R8();
    ctl_en = 1'b0; ctl_tsel = 4'd0;
    do_restart();
    cfg_force_en = 1'b1; // after capture: must be ignored (R9)
    repeat (300) @(negedge clk);
    check(!irq_flag && !sys_rst, "R8 disabled no time-out", irq_flag, 0);
    check(!irq_flag, "R9 late force ignored", irq_flag, 0);
    cfg_force_en = 1'b0;
  endtask

  task automatic t_intervals_R1();
    int codes[7] = '{0, 1, 2, 3, 4, 9, 15};
    int n;
    ctl_en = 1'b1; ctl_rst_en = 1'b0;
    foreach (codes[k]) begin
      ctl_tsel = 4'(codes[k]);
      do_restart();
      wait_flag(n, 1100);
      check(n == exp_period(codes[k]), $sformatf("R1 period code %0d", codes[k]),
            n, exp_period(codes[k]));
    end
  endtask

  task automatic t_irq_gate_R2();
    int n;
    ctl_tsel = 4'd0; ctl_irq_en = 1'b0;
    do_restart();
    wait_flag(n, 100);
    check(irq_flag && !irq, "R2 irq masked", irq, 0);
    ctl_irq_en = 1'b1;
    @(negedge clk);
    check(irq, "R2 irq enabled", irq, 1);
  endtask

  task automatic t_w1c_R10();
    clr_irq = 1'b1;
    @(negedge clk);
    clr_irq = 1'b0;
    check(!irq_flag, "R10 write-1 clear", irq_flag, 0);
    do_restart();
    repeat (exp_period(0) - 1) @(negedge clk);
    clr_irq = 1'b1;
    @(negedge clk);
    clr_irq = 1'b0;
    check(irq_flag, "R10 set wins over clear", irq_flag, 1);
  endtask

  task automatic t_wake_R6();
    int n;
    ctl_tsel = 4'd0; ctl_wake_en = 1'b1; src_is_slow = 1'b0;
    do_restart();
    wait_flag(n, 100);
    @(negedge clk);
    check(!wake_flag && !wake_req, "R6 fast source no wake", wake_flag, 0);
    src_is_slow = 1'b1;
    do_restart();
    wait_flag(n, 100);
    check(wake_flag && wake_req, "R6 slow source wake", wake_req, 1);
    ctl_wake_en = 1'b0;
    do_restart();
    wait_flag(n, 100);
    @(negedge clk);
    check(!wake_flag, "R6 wake disabled", wake_flag, 0);
    src_is_slow = 1'b0;
  endtask

  task automatic t_no_rst_R5();
    int n;
    int seen = 0;
    ctl_rst_en = 1'b0; ctl_dsel = 2'd3; ctl_tsel = 4'd0;
    do_restart();
    wait_flag(n, 100);
    repeat (100) begin
      @(negedge clk);
      if (sys_rst) seen++;
    end
    check(seen == 0 && !rst_flag, "R5 no reset when disabled", seen, 0);
  endtask

  task automatic t_grace_R3();
    int n, m, h;
    ctl_rst_en = 1'b1; ctl_tsel = 4'd0;
    for (int d = 3; d >= 0; d--) begin
      ctl_dsel = 2'(d);
      do_restart();
      wait_flag(n, 100);
      m = 0;
      while (!sys_rst && m < 1200) begin
        @(negedge clk);
        m++;
      end
      // R11: time-outs every 16 cycles during the window do not restart it
      check(m == exp_grace(d), $sformatf("R3 R11 grace code %0d", d), m, exp_grace(d));
      check(rst_flag, "R4 reset flag with pulse", rst_flag, 1);
      h = 1;
      while (h < 200) begin
        @(negedge clk);
        if (!sys_rst) break;
        h++;
      end
      check(h == PULSE_LEN, "R4 R11 pulse width", h, PULSE_LEN);
    end
  endtask

  task automatic t_cancel_R7();
    int n;
    int seen = 0;
    ctl_rst_en = 1'b1; ctl_tsel = 4'd3; ctl_dsel = 2'd1;
    do_restart();
    wait_flag(n, 1100);
    repeat (50) @(negedge clk);
    do_restart();
    repeat (200) begin
      @(negedge clk);
      if (sys_rst) seen++;
    end
    check(seen == 0 && !rst_flag, "R7 restart cancels grace", seen, 0);
    ctl_rst_en = 1'b0;
  endtask

  task automatic t_forced_R9();
    int n;
    ctl_en = 1'b0; ctl_tsel = 4'd0;
    apply_reset(1'b1);
    @(negedge clk);
    cfg_force_en = 1'b0;
    n = 0;
    wait_flag(n, 100);
    check(n == exp_period(0), "R9 forced enable runs", n, exp_period(0));
    apply_reset(1'b0);
    @(negedge clk);
    cfg_force_en = 1'b1;
    repeat (100) @(negedge clk);
    check(!irq_flag, "R9 not forced stays idle", irq_flag, 0);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_checks++;
          n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
          $finish;
        end
      end
    join_none
    apply_reset(1'b0);
    @(negedge clk);
    t_reset_state();
    t_disabled_R8();
    t_intervals_R1();
    t_irq_gate_R2();
    t_w1c_R10();
    t_wake_R6();
    t_no_rst_R5();
    t_grace_R3();
    t_cancel_R7();
    t_forced_R9();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule